// File: doc/BRIEF.md
# Snooping Coherent Private Data Cache Controller

This block is the private write-back data cache of one core in a multiprocessor whose caches share a snooping bus. It keeps a coherence state for every line, and the static input `moesi_mode` selects between two controllers. With `moesi_mode` low the controller has four states: Invalid, Shared, Exclusive and Modified. With `moesi_mode` high it adds a fifth state, Owned, in which the cache may keep a dirty line while other caches hold copies of it. The cache is fully associative with a few lines. Each line holds `WORDS` words of `WORD_W` bits, which is eight 64-bit words (64 bytes) by default. Victims are chosen in least-recently-used order.

The core presents one word access at a time and holds it until `core_ack` pulses. Misses and upgrades become one bus request. The arbiter answers it with `bus_gnt` and then returns a single response beat. If no other cache supplies the data, the line is read over the memory port. Requests that other caches place on the bus arrive on the snoop port. Each one gets a registered reply one cycle later, which can include the line data for a cache-to-cache transfer. Dirty lines leave through the memory write port. The environment guarantees that no snoop arrives while this cache's own granted transaction is in flight, so that only one transaction is on the bus at a time.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `core_ack`, `bus_req`, `snp_rsp_valid`, `mem_rd_req` and `mem_wr_valid` are all low.
- R2: A read miss issues `bus_cmd`=1 (read). If the response has `bus_rsp_supplied`=0, `mem_rd_req` pulses for one cycle and the line is filled from `mem_rd_data`. It is installed Exclusive if `bus_rsp_shared` was 0 and Shared otherwise. The requested word (bits `w*64 +: 64` of the line, with `w` = `core_addr[2:0]`) is returned.
- R3: A read that hits a line in Modified, Owned, Exclusive or Shared returns the stored word and makes no bus request.
- R4: A snooped read (`snp_cmd`=1) that hits an Exclusive line replies with hit and supply, returns the line, and leaves the line Shared. A Shared line answers hit without supply.
- R5: A write hit on Exclusive or Modified ends in Modified with no bus request. A write hit on Shared or Owned issues `bus_cmd`=3 (invalidate) and ends in Modified once the response arrives.
- R6: A snooped invalidate (`snp_cmd`=3) or read-for-ownership (`snp_cmd`=2) that hits makes the line Invalid. A read-for-ownership is supplied from Exclusive, Owned or Modified without a memory write.
- R7: With `moesi_mode`=0, a snooped read that hits a Modified line supplies the line, writes it to memory in the same reply cycle, and leaves it Shared.
- R8: With `moesi_mode`=1, a snooped read that hits a Modified or Owned line supplies it with no memory write and leaves it Owned. An Owned line reaches memory only when it is evicted.
- R9: A write miss issues `bus_cmd`=2 (read-for-ownership). It takes the line from the bus response when it is supplied, or otherwise from memory, merges the written word, and installs the line Modified.
- R10: A fill takes an Invalid line if one exists, otherwise the least recently used line. Evicting a Modified or Owned line pulses `mem_wr_valid` with its address and data. Evicting a Shared or Exclusive line writes nothing.
- R11: A snoop has priority over the core. A core request is not accepted in a cycle that carries a snoop. If a snoop invalidates the line that a pending write wanted to upgrade, the request becomes read-for-ownership.
- R12: `core_ack` is a single-cycle pulse per access. `bus_req` drops in the cycle after it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| moesi_mode | input | 1 | Static protocol select: 0 four-state, 1 with Owned |
| core_req | input | 1 | Core access pending, held until acknowledged |
| core_we | input | 1 | 1 write, 0 read |
| core_addr | input | TAG_W+3 | Line address in upper bits, word index in low bits |
| core_wdata | input | WORD_W | Write word |
| core_ack | output | 1 | Access complete pulse |
| core_rdata | output | WORD_W | Read word, valid with core_ack |
| bus_req | output | 1 | Bus request pending |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 invalidate |
| bus_addr | output | TAG_W | Line address of the request |
| bus_gnt | input | 1 | Request granted this cycle |
| bus_rsp_valid | input | 1 | Response beat for the granted request |
| bus_rsp_supplied | input | 1 | Another cache supplied the line |
| bus_rsp_shared | input | 1 | Another cache keeps a copy |
| bus_rsp_data | input | WORDS*WORD_W | Line supplied by another cache |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | TAG_W | Snooped line address |
| snp_rsp_valid | output | 1 | Snoop reply, one cycle after snp_valid |
| snp_rsp_hit | output | 1 | Line was present |
| snp_rsp_supply | output | 1 | This cache supplies the line |
| snp_rsp_data | output | WORDS*WORD_W | Supplied line |
| mem_rd_req | output | 1 | Line read request pulse |
| mem_rd_addr | output | TAG_W | Line address to read |
| mem_rd_valid | input | 1 | Memory line data valid |
| mem_rd_data | input | WORDS*WORD_W | Memory line data |
| mem_wr_valid | output | 1 | Write-back pulse |
| mem_wr_addr | output | TAG_W | Write-back line address |
| mem_wr_data | output | WORDS*WORD_W | Write-back line data |

## Verification
The directed part goes after the snooped read of a dirty line in both modes. A design that swapped the two behaviours would either leave memory stale in the four-state mode or write memory when it should keep ownership, and the bench's memory model and write-back counter show both. It also checks that a write to a Shared or Owned line is an invalidate and not silent, that a line survives a supply as the correct sharer or owner, and that the LRU victim picks the dirty line and writes it back while a clean victim makes no memory write. The snoop-versus-core collision checks that the upgrade turns into read-for-ownership; a design that kept the upgrade would write into a line it no longer holds. Random reads, writes and snoops then compare every returned word against a bench model of the most recent write.

// File: rtl/snc_pkg.sv
package snc_pkg;
    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } coh_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RFO  = 2'd2,
        CMD_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_RSP  = 2'd2,
        F_MEM  = 2'd3
    } fsm_e;
endpackage

// File: rtl/snc_match.sv
module snc_match #(
    parameter int LINES = 4,
    parameter int TAG_W = 16
) (
    input  snc_pkg::coh_e [LINES-1:0]             st,
    input  logic          [LINES-1:0][TAG_W-1:0]  tag,
    input  logic          [TAG_W-1:0]             addr,
    output logic                                  hit,
    output logic          [$clog2(LINES)-1:0]     idx
);
    localparam int IDX_W = $clog2(LINES);

    logic [LINES-1:0] way_hit;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign way_hit[g] = (st[g] != snc_pkg::ST_I) && (tag[g] == addr);
    end

    always_comb begin
        hit = |way_hit;
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (way_hit[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/snc_victim.sv
module snc_victim #(
    parameter int LINES = 4
) (
    input  snc_pkg::coh_e [LINES-1:0]                     st,
    input  logic          [LINES-1:0][$clog2(LINES)-1:0]  age,
    output logic          [$clog2(LINES)-1:0]             idx
);
    localparam int IDX_W = $clog2(LINES);

    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < LINES; i++) begin
            if (!found && st[i] == snc_pkg::ST_I) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < LINES; i++) begin
                if (age[i] == IDX_W'(LINES - 1)) idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import snc_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int TAG_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        moesi_mode,
    input  logic                        core_req,
    input  logic                        core_we,
    input  logic [TAG_W+$clog2(WORDS)-1:0] core_addr,
    input  logic [WORD_W-1:0]           core_wdata,
    output logic                        core_ack,
    output logic [WORD_W-1:0]           core_rdata,
    output logic                        bus_req,
    output logic [1:0]                  bus_cmd,
    output logic [TAG_W-1:0]            bus_addr,
    input  logic                        bus_gnt,
    input  logic                        bus_rsp_valid,
    input  logic                        bus_rsp_supplied,
    input  logic                        bus_rsp_shared,
    input  logic [WORDS*WORD_W-1:0]     bus_rsp_data,
    input  logic                        snp_valid,
    input  logic [1:0]                  snp_cmd,
    input  logic [TAG_W-1:0]            snp_addr,
    output logic                        snp_rsp_valid,
    output logic                        snp_rsp_hit,
    output logic                        snp_rsp_supply,
    output logic [WORDS*WORD_W-1:0]     snp_rsp_data,
    output logic                        mem_rd_req,
    output logic [TAG_W-1:0]            mem_rd_addr,
    input  logic                        mem_rd_valid,
    input  logic [WORDS*WORD_W-1:0]     mem_rd_data,
    output logic                        mem_wr_valid,
    output logic [TAG_W-1:0]            mem_wr_addr,
    output logic [WORDS*WORD_W-1:0]     mem_wr_data
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);

    typedef struct packed {
        fsm_e                               fsm;
        bus_cmd_e                           cmd;
        logic                               shared;
        coh_e [LINES-1:0]                   st;
        logic [LINES-1:0][TAG_W-1:0]        tag;
        logic [LINES-1:0][IDX_W-1:0]        age;
        logic [LINES-1:0][LINE_W-1:0]       data;
        logic                               ack;
        logic [WORD_W-1:0]                  rdata;
        logic                               breq;
        logic                               srv;
        logic                               shit;
        logic                               ssup;
        logic [LINE_W-1:0]                  sdata;
        logic                               mrd;
        logic                               mwr;
        logic [TAG_W-1:0]                   mwaddr;
        logic [LINE_W-1:0]                  mwdata;
    } regs_t;

    regs_t q, d;

    logic [TAG_W-1:0]  c_tag;
    logic [WIDX_W-1:0] c_w;
    logic              c_hit, s_hit;
    logic [IDX_W-1:0]  c_idx, s_idx, v_idx;

    assign c_tag = core_addr[WIDX_W +: TAG_W];
    assign c_w   = core_addr[WIDX_W-1:0];

    snc_match #(.LINES(LINES), .TAG_W(TAG_W)) u_core_match (
        .st(q.st), .tag(q.tag), .addr(c_tag), .hit(c_hit), .idx(c_idx)
    );
    snc_match #(.LINES(LINES), .TAG_W(TAG_W)) u_snoop_match (
        .st(q.st), .tag(q.tag), .addr(snp_addr), .hit(s_hit), .idx(s_idx)
    );
    snc_victim #(.LINES(LINES)) u_victim (
        .st(q.st), .age(q.age), .idx(v_idx)
    );

    always_comb begin
        logic             touch;
        logic [IDX_W-1:0] tgt;
        logic             inst;
        logic             inst_shr;
        logic [LINE_W-1:0] fill;
        logic             c_live;

        d        = q;
        d.ack    = 1'b0;
        d.srv    = 1'b0;
        d.shit   = 1'b0;
        d.ssup   = 1'b0;
        d.mrd    = 1'b0;
        d.mwr    = 1'b0;
        touch    = 1'b0;
        tgt      = c_idx;
        inst     = 1'b0;
        inst_shr = 1'b0;
        fill     = bus_rsp_data;

        // snooped request: handled first, blocks the core for this cycle
        if (snp_valid) begin
            d.srv = 1'b1;
            if (s_hit) begin
                d.shit  = 1'b1;
                d.sdata = q.data[s_idx];
                case (bus_cmd_e'(snp_cmd))
                    CMD_RD: begin
                        if (q.st[s_idx] == ST_E) begin
                            d.ssup = 1'b1;
                            d.st[s_idx] = ST_S;
                        end else if (q.st[s_idx] == ST_O) begin
                            d.ssup = 1'b1;
                        end else if (q.st[s_idx] == ST_M) begin
                            d.ssup = 1'b1;
                            if (moesi_mode) begin
                                d.st[s_idx] = ST_O;
                            end else begin
                                d.st[s_idx] = ST_S;
                                d.mwr    = 1'b1;
                                d.mwaddr = q.tag[s_idx];
                                d.mwdata = q.data[s_idx];
                            end
                        end
                    end
                    CMD_RFO: begin
                        d.ssup = (q.st[s_idx] != ST_S);
                        d.st[s_idx] = ST_I;
                    end
                    CMD_UPG: d.st[s_idx] = ST_I;
                    default: ;
                endcase
            end
        end

        // core line still valid after any invalidation in this cycle
        c_live = c_hit && !(snp_valid && s_hit && s_idx == c_idx &&
                            bus_cmd_e'(snp_cmd) inside {CMD_RFO, CMD_UPG});

        case (q.fsm)
            F_IDLE: begin
                if (core_req && !snp_valid && !q.ack) begin
                    if (c_hit && (!core_we || q.st[c_idx] == ST_E || q.st[c_idx] == ST_M)) begin
                        touch   = 1'b1;
                        d.ack   = 1'b1;
                        d.rdata = q.data[c_idx][c_w*WORD_W +: WORD_W];
                        if (core_we) begin
                            d.data[c_idx][c_w*WORD_W +: WORD_W] = core_wdata;
                            d.st[c_idx] = ST_M;
                        end
                    end else begin
                        d.fsm  = F_REQ;
                        d.breq = 1'b1;
                        d.cmd  = !core_we ? CMD_RD : (c_hit ? CMD_UPG : CMD_RFO);
                    end
                end
            end
            F_REQ: begin
                d.cmd = !core_we ? CMD_RD : (c_live ? CMD_UPG : CMD_RFO);
                if (bus_gnt && !snp_valid) begin
                    d.breq = 1'b0;
                    d.fsm  = F_RSP;
                end
            end
            F_RSP: begin
                if (bus_rsp_valid) begin
                    if (q.cmd == CMD_UPG) begin
                        d.st[c_idx] = ST_M;
                        d.data[c_idx][c_w*WORD_W +: WORD_W] = core_wdata;
                        touch = 1'b1;
                        d.ack = 1'b1;
                        d.fsm = F_IDLE;
                    end else if (bus_rsp_supplied) begin
                        inst     = 1'b1;
                        inst_shr = bus_rsp_shared;
                        fill     = bus_rsp_data;
                    end else begin
                        d.shared = bus_rsp_shared;
                        d.mrd    = 1'b1;
                        d.fsm    = F_MEM;
                    end
                end
            end
            F_MEM: begin
                if (mem_rd_valid) begin
                    inst     = 1'b1;
                    inst_shr = q.shared;
                    fill     = mem_rd_data;
                end
            end
            default: d.fsm = F_IDLE;
        endcase

        if (inst) begin
            tgt = v_idx;
            if (q.st[v_idx] == ST_M || q.st[v_idx] == ST_O) begin
                d.mwr    = 1'b1;
                d.mwaddr = q.tag[v_idx];
                d.mwdata = q.data[v_idx];
            end
            if (core_we) fill[c_w*WORD_W +: WORD_W] = core_wdata;
            d.data[v_idx] = fill;
            d.tag[v_idx]  = c_tag;
            d.st[v_idx]   = core_we ? ST_M : (inst_shr ? ST_S : ST_E);
            d.rdata       = fill[c_w*WORD_W +: WORD_W];
            d.ack         = 1'b1;
            d.fsm         = F_IDLE;
            touch         = 1'b1;
        end

        if (touch) begin
            for (int j = 0; j < LINES; j++) begin
                if (q.age[j] < q.age[tgt]) d.age[j] = q.age[j] + 1'b1;
            end
            d.age[tgt] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            for (int i = 0; i < LINES; i++) q.age[i] <= IDX_W'(i);
        end else begin
            q <= d;
        end
    end

    assign core_ack       = q.ack;
    assign core_rdata     = q.rdata;
    assign bus_req        = q.breq;
    assign bus_cmd        = q.cmd;
    assign bus_addr       = c_tag;
    assign snp_rsp_valid  = q.srv;
    assign snp_rsp_hit    = q.shit;
    assign snp_rsp_supply = q.ssup;
    assign snp_rsp_data   = q.sdata;
    assign mem_rd_req     = q.mrd;
    assign mem_rd_addr    = c_tag;
    assign mem_wr_valid   = q.mwr;
    assign mem_wr_addr    = q.mwaddr;
    assign mem_wr_data    = q.mwdata;
endmodule

// File: rtl/snc_checker.sv
module snc_checker (
    input logic clk,
    input logic rst_n,
    input logic moesi_mode,
    input logic core_ack,
    input logic bus_req,
    input logic bus_gnt,
    input logic snp_valid,
    input logic snp_rsp_valid,
    input logic snp_rsp_hit,
    input logic snp_rsp_supply,
    input logic mem_rd_req,
    input logic mem_wr_valid
);
    a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !core_ack);

    a_r12_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt && !snp_valid |=> !bus_req);

    a_r11_snoop_reply: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> snp_rsp_valid);

    a_r6_supply_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        snp_rsp_supply |-> snp_rsp_hit && snp_rsp_valid);

    a_r8_owned_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        moesi_mode && snp_rsp_valid |-> !mem_wr_valid);

    a_r2_memrd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);
endmodule

bind snoop_cache_ctrl snc_checker u_snc_checker (
    .clk(clk), .rst_n(rst_n), .moesi_mode(moesi_mode), .core_ack(core_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .snp_valid(snp_valid),
    .snp_rsp_valid(snp_rsp_valid), .snp_rsp_hit(snp_rsp_hit),
    .snp_rsp_supply(snp_rsp_supply), .mem_rd_req(mem_rd_req),
    .mem_wr_valid(mem_wr_valid)
);

// File: tb/test_snoop_cache_ctrl.sv
`timescale 1ns/1ps
module test_snoop_cache_ctrl;
    localparam int TAG_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic moesi_mode = 1'b0;
    logic core_req = 1'b0, core_we = 1'b0;
    logic [TAG_W+2:0] core_addr = '0;
    logic [63:0] core_wdata = '0;
    logic core_ack;
    logic [63:0] core_rdata;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [TAG_W-1:0] bus_addr;
    logic bus_gnt = 1'b0, bus_rsp_valid = 1'b0, bus_rsp_supplied = 1'b0, bus_rsp_shared = 1'b0;
    logic [511:0] bus_rsp_data = '0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [TAG_W-1:0] snp_addr = '0;
    logic snp_rsp_valid, snp_rsp_hit, snp_rsp_supply;
    logic [511:0] snp_rsp_data;
    logic mem_rd_req;
    logic [TAG_W-1:0] mem_rd_addr;
    logic mem_rd_valid = 1'b0;
    logic [511:0] mem_rd_data = '0;
    logic mem_wr_valid;
    logic [TAG_W-1:0] mem_wr_addr;
    logic [511:0] mem_wr_data;

    int checks = 0;
    int fails = 0;
    int wb_cnt = 0;
    logic [TAG_W-1:0] last_wb_addr;
    logic [511:0] mem [16];
    logic [63:0] gold [16][8];

    always #2.5 clk = ~clk;

    snoop_cache_ctrl i_snoop_cache_ctrl (.*);

    always @(posedge clk) begin
        if (mem_wr_valid) begin
            wb_cnt++;
            last_wb_addr = mem_wr_addr;
            mem[mem_wr_addr[3:0]] = mem_wr_data;
        end
    end

    function automatic logic [63:0] pat(input int line, input int w);
        return {16'hC0DE, 16'(line), 16'h5A00, 16'(w)};
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0;
        moesi_mode = mode;
        for (int l = 0; l < 16; l++)
            for (int w = 0; w < 8; w++) begin
                mem[l][w*64 +: 64] = pat(l, w);
                gold[l][w] = pat(l, w);
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic core_op(input bit we, input int line, input int w, input logic [63:0] wd,
                           input bit sup, input bit shr, input logic [511:0] sd,
                           input bit sen, input logic [1:0] sc,
                           output logic [63:0] rd, output logic [1:0] cmd);
        bit gave = 0;
        bit done = 0;
        core_req = 1'b1; core_we = we; core_addr = {16'(line), 3'(w)}; core_wdata = wd;
        snp_valid = sen; snp_cmd = sc; snp_addr = 16'(line);
        cmd = 2'd0; rd = '0;
        for (int n = 0; n < 60 && !done; n++) begin
            @(negedge clk);
            snp_valid = 1'b0;
            bus_gnt = 1'b0; bus_rsp_valid = 1'b0; mem_rd_valid = 1'b0;
            if (gave) begin
                bus_rsp_valid = 1'b1; bus_rsp_supplied = sup; bus_rsp_shared = shr;
                bus_rsp_data = sd; gave = 0;
            end
            if (core_ack) begin
                rd = core_rdata; done = 1;
            end else begin
                if (bus_req) begin bus_gnt = 1'b1; cmd = bus_cmd; gave = 1; end
                if (mem_rd_req) begin mem_rd_valid = 1'b1; mem_rd_data = mem[mem_rd_addr[3:0]]; end
            end
        end
        core_req = 1'b0;
        bus_rsp_valid = 1'b0;
        if (!done) begin
            fails++;
            $display("FAIL R12 no core_ack actual=0 expected=1");
        end
        @(negedge clk);
    endtask

    task automatic snoop(input logic [1:0] c, input int line,
                         output logic hit, output logic sup, output logic [511:0] data);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = 16'(line);
        @(negedge clk);
        snp_valid = 1'b0;
        hit = snp_rsp_hit; sup = snp_rsp_supply; data = snp_rsp_data;
        @(negedge clk);
    endtask

    logic [63:0] rd;
    logic [1:0] cmd;
    logic h, s;
    logic [511:0] sd;
    int wb0;

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        // R1: reset state
        check("R1 ack", core_ack, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 wr", mem_wr_valid, 0);
        check("R1 snp", snp_rsp_valid, 0);
        snoop(2'd1, 1, h, s, sd);
        check("R1 empty snoop hit", h, 0);

        // R2: read miss from memory, installed Exclusive
        core_op(0, 1, 2, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R2 cmd read", cmd, 1);
        check("R2 data", rd, pat(1, 2));
        // R5: write hit on Exclusive is silent
        core_op(1, 1, 2, 64'h1111, 0, 0, '0, 0, 0, rd, cmd);
        check("R5 silent E write", cmd, 0);
        // R3: read hit on Modified
        core_op(0, 1, 2, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R3 hit no bus", cmd, 0);
        check("R3 hit data", rd, 64'h1111);
        // R7: four-state snooped read of Modified
        wb0 = wb_cnt;
        snoop(2'd1, 1, h, s, sd);
        check("R7 supply", s, 1);
        check("R7 data", sd[2*64 +: 64], 64'h1111);
        check("R7 wb count", wb_cnt, wb0 + 1);
        check("R7 mem updated", mem[1][2*64 +: 64], 64'h1111);
        // R5: write to Shared issues invalidate
        core_op(1, 1, 3, 64'h2222, 0, 0, '0, 0, 0, rd, cmd);
        check("R5 upgrade cmd", cmd, 3);
        // R6: snooped invalidate then read misses; supplied fill shared
        snoop(2'd3, 1, h, s, sd);
        check("R6 inv hit", h, 1);
        check("R6 inv no supply", s, 0);
        sd = {8{64'hABCD}};
        core_op(0, 1, 3, 0, 1, 1, sd, 0, 0, rd, cmd);
        check("R6 miss after inv", cmd, 1);
        check("R2 supplied data", rd, 64'hABCD);
        snoop(2'd1, 1, h, s, sd);
        check("R4 shared hit", h, 1);
        check("R4 shared no supply", s, 0);
        // R9: write miss from memory
        core_op(1, 2, 5, 64'h3333, 0, 0, '0, 0, 0, rd, cmd);
        check("R9 rfo cmd", cmd, 2);
        core_op(0, 2, 5, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R9 merged word", rd, 64'h3333);
        core_op(0, 2, 4, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R9 fill word", rd, pat(2, 4));
        // R10: LRU eviction
        core_op(0, 3, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        core_op(0, 4, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        core_op(0, 1, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R3 touch hit", cmd, 0);
        wb0 = wb_cnt;
        core_op(0, 5, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R10 dirty wb", wb_cnt, wb0 + 1);
        check("R10 wb addr", last_wb_addr, 2);
        check("R10 wb data", mem[2][5*64 +: 64], 64'h3333);
        wb0 = wb_cnt;
        core_op(0, 6, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R10 clean silent", wb_cnt, wb0);
        // R4: snooped read of Exclusive
        snoop(2'd1, 5, h, s, sd);
        check("R4 E supply", s, 1);
        check("R4 E data", sd[63:0], pat(5, 0));
        core_op(1, 5, 1, 64'h4444, 0, 0, '0, 0, 0, rd, cmd);
        check("R4 now shared", cmd, 3);
        core_op(0, 2, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R10 evicted miss", cmd, 1);
        // R11: snoop collides with write to a Shared line
        core_op(1, 1, 0, 64'h5555, 0, 0, '0, 1, 2'd3, rd, cmd);
        check("R11 upgrade became rfo", cmd, 2);

        // MOESI mode
        do_reset(1'b1);
        core_op(0, 1, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        core_op(1, 1, 0, 64'h6666, 0, 0, '0, 0, 0, rd, cmd);
        wb0 = wb_cnt;
        snoop(2'd1, 1, h, s, sd);
        check("R8 supply", s, 1);
        check("R8 data", sd[63:0], 64'h6666);
        check("R8 no wb", wb_cnt, wb0);
        core_op(0, 1, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R3 owned hit", cmd, 0);
        check("R3 owned data", rd, 64'h6666);
        snoop(2'd1, 1, h, s, sd);
        check("R8 owned supplies", s, 1);
        core_op(1, 1, 1, 64'h7777, 0, 0, '0, 0, 0, rd, cmd);
        check("R5 owned upgrade", cmd, 3);
        snoop(2'd1, 1, h, s, sd);
        core_op(0, 2, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        core_op(0, 3, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        core_op(0, 4, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R8 mem stale before evict", mem[1][63:0], pat(1, 0));
        wb0 = wb_cnt;
        core_op(0, 5, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R8 evict wb", wb_cnt, wb0 + 1);
        check("R8 evict w0", mem[1][63:0], 64'h6666);
        check("R8 evict w1", mem[1][127:64], 64'h7777);
        core_op(1, 2, 0, 64'h8888, 0, 0, '0, 0, 0, rd, cmd);
        check("R5 E write silent", cmd, 0);
        wb0 = wb_cnt;
        snoop(2'd2, 2, h, s, sd);
        check("R6 rfo supply", s, 1);
        check("R6 rfo data", sd[63:0], 64'h8888);
        check("R6 rfo no wb", wb_cnt, wb0);
        core_op(0, 2, 0, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R6 rfo invalidated", cmd, 1);
        sd = {8{64'h9999}};
        core_op(1, 7, 6, 64'hAAAA, 1, 1, sd, 0, 0, rd, cmd);
        check("R9 rfo supplied", cmd, 2);
        core_op(0, 7, 5, 0, 0, 0, '0, 0, 0, rd, cmd);
        check("R9 supplied word", rd, 64'h9999);
        core_op(1, 7, 0, 64'hBBBB, 0, 0, '0, 0, 0, rd, cmd);
        check("R9 installed modified", cmd, 0);

        // random phase in both modes, R3/R7/R8 data consistency
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int it = 0; it < 400; it++) begin
                int line = int'($urandom_range(0, 5));
                int w = int'($urandom_range(0, 7));
                if ($urandom_range(0, 3) == 0) begin
                    snoop(2'd1, line, h, s, sd);
                    if (s) check("R7/R8 random supply", sd[w*64 +: 64], gold[line][w]);
                end else if ($urandom_range(0, 1) == 1) begin
                    logic [63:0] wd = {$urandom, $urandom};
                    core_op(1, line, w, wd, 0, 0, '0, 0, 0, rd, cmd);
                    gold[line][w] = wd;
                end else begin
                    core_op(0, line, w, 0, 0, 0, '0, 0, 0, rd, cmd);
                    check("R3 random read", rd, gold[line][w]);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule